// File: doc/BRIEF.md
# Set/Clear Masked Interrupt Controller

This block gathers level-sensitive requests from peripherals into two independent banks: a normal interrupt bank and a fast interrupt bank. Each bank has a 32-bit request vector, driven straight from its source pins, and a 32-bit enable mask. Each bank drives one registered processor interrupt line. That line is high when any request bit is present with its enable bit set.

Software reaches the block through a simple register port: a request strobe, a write flag, a word address and write data. Read data and an error pulse both appear one cycle later. Software never writes the mask directly. It adds enables through a set register and removes them through a clear register, so that concurrent drivers need no read-modify-write. Either bank can be read in two views: raw requests, or requests gated by the mask.

Top module: `setclr_intc`

Word address layout: bit 2 picks the bank (0 = normal, 1 = fast). Bits 1:0 pick the register: 0 = masked status, 1 = raw status, 2 = enable set, 3 = enable clear. Any address with bit 3 set is illegal.

## Requirements
- R1: A read of a raw status register returns that bank's request inputs, as sampled in the access cycle, regardless of the mask. The data appears on the read data output one cycle later.
- R2: A read of a masked status register returns that bank's request inputs ANDed with its enable mask, with the same one-cycle latency.
- R3: A write to an enable set register ORs the write data into that bank's mask. Zero bits leave their mask bits unchanged.
- R4: A write to an enable clear register clears each mask bit where the write data holds a one. Other bits are left unchanged.
- R5: The fast bank has its own mask. Set and clear writes to one bank never alter the other bank's mask.
- R6: A write to a status register (register 0 or 1) pulses the error output high for one cycle and changes no mask.
- R7: Each interrupt output equals the OR of its bank's masked requests, registered once. A mask change takes effect on the output at the clock edge after the one that stores it.
- R8: A read of an enable set or enable clear register returns that bank's current mask and pulses the error output for one cycle.
- R9: After reset, both masks are zero and the interrupt outputs, the error output and the read data are all zero.
- R10: An access to an address with bit 3 set pulses the error output, changes no state, and a read of such an address returns zero.
- R11: Legal accesses (status reads, and set or clear writes) leave the error output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_src_i | input | 32 | Normal bank request levels |
| fiq_src_i | input | 32 | Fast bank request levels |
| req_valid_i | input | 1 | Register access strobe, one cycle per access |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 4 | Word address |
| req_wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| err_o | output | 1 | One-cycle illegal access pulse |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
Every result is due exactly one clock edge after the access or request that causes it. Read data and the error pulse follow the access edge. A mask write lands at the access edge, and the interrupt line shows the new mask one edge after that. The bench steps a reference model at each rising edge from the same inputs. It compares outputs at the falling edge that follows, and it compares read data only in the cycle right after a read. Directed accesses then pin down mask values through reads of the set registers.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    REG_MASKED = 2'd0,
    REG_RAW    = 2'd1,
    REG_SET    = 2'd2,
    REG_CLR    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] masked_o,
  output logic         int_o
);
  logic [W-1:0] mask_q;
  logic         int_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      int_q  <= 1'b0;
    end else begin
      int_q <= |(src_i & mask_q);
      if (set_i)      mask_q <= mask_q | wdata_i;
      else if (clr_i) mask_q <= mask_q & ~wdata_i;
    end
  end

  assign mask_o   = mask_q;
  assign masked_o = src_i & mask_q;
  assign int_o    = int_q;
endmodule

// File: rtl/intc_regif.sv
module intc_regif
  import intc_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 4,
  parameter int NB = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 write_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [NB-1:0][W-1:0] raw_i,
  input  logic [NB-1:0][W-1:0] masked_i,
  input  logic [NB-1:0][W-1:0] mask_i,
  output logic [NB-1:0]        set_o,
  output logic [NB-1:0]        clr_o,
  output logic [W-1:0]         rdata_o,
  output logic                 err_o
);
  localparam int BANK_BIT = 2;

  logic        legal;
  logic        bank;
  reg_sel_e    sel;
  logic        err_d;
  logic [W-1:0] rd_d, rdata_q;
  logic        err_q;

  assign legal = (addr_i[AW-1:BANK_BIT+1] == '0);
  assign bank  = addr_i[BANK_BIT];
  assign sel   = reg_sel_e'(addr_i[1:0]);

  always_comb begin
    set_o = '0;
    clr_o = '0;
    err_d = 1'b0;
    rd_d  = '0;
    if (valid_i) begin
      if (!legal) begin
        err_d = 1'b1;
      end else begin
        unique case (sel)
          REG_MASKED: if (write_i) err_d = 1'b1; else rd_d = masked_i[bank];
          REG_RAW:    if (write_i) err_d = 1'b1; else rd_d = raw_i[bank];
          REG_SET:    if (write_i) set_o[bank] = 1'b1;
                      else begin rd_d = mask_i[bank]; err_d = 1'b1; end
          REG_CLR:    if (write_i) clr_o[bank] = 1'b1;
                      else begin rd_d = mask_i[bank]; err_d = 1'b1; end
          default:    err_d = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= err_d;
      if (valid_i && !write_i) rdata_q <= rd_d;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;
endmodule

// File: rtl/setclr_intc.sv
module setclr_intc #(
  parameter int W  = 32,
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  irq_src_i,
  input  logic [W-1:0]  fiq_src_i,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [W-1:0]  req_wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic          err_o,
  output logic          irq_o,
  output logic          fiq_o
);
  localparam int NB = 2;

  logic [NB-1:0][W-1:0] src, masked, mask;
  logic [NB-1:0]        set_en, clr_en, int_out;
  logic [W-1:0]         irq_mask, fiq_mask;

  assign src[0] = irq_src_i;
  assign src[1] = fiq_src_i;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    intc_bank #(.W(W)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (src[b]),
      .set_i    (set_en[b]),
      .clr_i    (clr_en[b]),
      .wdata_i  (req_wdata_i),
      .mask_o   (mask[b]),
      .masked_o (masked[b]),
      .int_o    (int_out[b])
    );
  end

  intc_regif #(.W(W), .AW(AW), .NB(NB)) u_regif (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (req_valid_i),
    .write_i  (req_write_i),
    .addr_i   (req_addr_i),
    .raw_i    (src),
    .masked_i (masked),
    .mask_i   (mask),
    .set_o    (set_en),
    .clr_o    (clr_en),
    .rdata_o  (rdata_o),
    .err_o    (err_o)
  );

  assign irq_mask = mask[0];
  assign fiq_mask = mask[1];
  assign irq_o    = int_out[0];
  assign fiq_o    = int_out[1];
endmodule

// File: rtl/setclr_intc_chk.sv
module setclr_intc_chk #(
  parameter int W  = 32,
  parameter int AW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [W-1:0]  irq_src_i,
  input logic [W-1:0]  fiq_src_i,
  input logic          req_valid_i,
  input logic          req_write_i,
  input logic [AW-1:0] req_addr_i,
  input logic [W-1:0]  req_wdata_i,
  input logic          err_o,
  input logic          irq_o,
  input logic          fiq_o,
  input logic [W-1:0]  irq_mask,
  input logic [W-1:0]  fiq_mask
);
  logic lgl, st_wr, set0, clr0;
  assign lgl   = req_valid_i && (req_addr_i[AW-1:3] == '0);
  assign st_wr = lgl && req_write_i && !req_addr_i[1];
  assign set0  = lgl && req_write_i && (req_addr_i[2:0] == 3'd2);
  assign clr0  = lgl && req_write_i && (req_addr_i[2:0] == 3'd3);

  AST_STATUS_WR_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_wr |=> err_o); // R6
  AST_STATUS_WR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_wr |=> ($stable(irq_mask) && $stable(fiq_mask))); // R6
  AST_SET_ORS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set0 |=> ((irq_mask & $past(req_wdata_i)) == $past(req_wdata_i))); // R3
  AST_CLR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr0 |=> ((irq_mask & $past(req_wdata_i)) == '0)); // R4
  AST_IRQ_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == |($past(irq_src_i) & $past(irq_mask)))); // R7
  AST_FIQ_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (fiq_o == |($past(fiq_src_i) & $past(fiq_mask)))); // R7
  AST_LEGAL_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lgl && (req_write_i == req_addr_i[1])) |=> !err_o); // R11
endmodule

bind setclr_intc setclr_intc_chk #(.W(W), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_src_i   (irq_src_i),
  .fiq_src_i   (fiq_src_i),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .req_wdata_i (req_wdata_i),
  .err_o       (err_o),
  .irq_o       (irq_o),
  .fiq_o       (fiq_o),
  .irq_mask    (irq_mask),
  .fiq_mask    (fiq_mask)
);

// File: tb/setclr_intc_tb_top.sv
module setclr_intc_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_src = '0, fiq_src = '0, wdata = '0;
  logic        valid = 1'b0, wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] rdata;
  logic        err, irq, fiq;

  int n_chk = 0, n_fail = 0;

  // reference model state
  logic [31:0] m_mask [2];
  logic        e_irq, e_fiq, e_err, e_rchk;
  logic [31:0] e_rd;
  string       e_tag, e_etag;

  setclr_intc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_src_i(irq_src), .fiq_src_i(fiq_src),
    .req_valid_i(valid), .req_write_i(wr), .req_addr_i(addr), .req_wdata_i(wdata),
    .rdata_o(rdata), .err_o(err), .irq_o(irq), .fiq_o(fiq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask[0] = '0; m_mask[1] = '0;
      e_irq = 0; e_fiq = 0; e_err = 0; e_rchk = 0; e_rd = '0;
      e_tag = "R9"; e_etag = "R9";
    end else begin
      int b;
      int r;
      logic [31:0] rawv;
      e_irq = |(irq_src & m_mask[0]);
      e_fiq = |(fiq_src & m_mask[1]);
      e_err = 0; e_rchk = 0; e_etag = "R11";
      b = addr[2];
      r = addr[1:0];
      rawv = b ? fiq_src : irq_src;
      if (valid) begin
        if (addr[3]) begin
          e_err = 1; e_etag = "R10";
          if (!wr) begin e_rchk = 1; e_rd = '0; e_tag = "R10"; end
        end else if (r < 2) begin
          if (wr) begin e_err = 1; e_etag = "R6"; end
          else begin
            e_rchk = 1;
            e_rd = (r == 0) ? (rawv & m_mask[b]) : rawv;
            e_tag = (r == 0) ? "R2" : "R1";
          end
        end else if (wr) begin
          if (r == 2) m_mask[b] = m_mask[b] | wdata;
          else        m_mask[b] = m_mask[b] & ~wdata;
        end else begin
          e_err = 1; e_etag = "R8";
          e_rchk = 1; e_rd = m_mask[b]; e_tag = "R8";
        end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R7 irq_o", {31'b0, irq}, {31'b0, e_irq});
    chk("R7 fiq_o", {31'b0, fiq}, {31'b0, e_fiq});
    chk({e_etag, " err_o"}, {31'b0, err}, {31'b0, e_err});
    if (e_rchk) chk({e_tag, " rdata_o"}, rdata, e_rd);
  end

  task automatic acc(bit w, logic [3:0] a, logic [31:0] d);
    valid = 1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    valid = 0; wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    acc(0, a, '0);
    d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    chk("R9 irq_o reset", {31'b0, irq}, 0);
    chk("R9 err_o reset", {31'b0, err}, 0);
    chk("R9 rdata reset", rdata, 0);
    rst_n = 1;
    @(negedge clk);
    rd(4'd2, v); chk("R9 irq mask zero", v, 0);
    rd(4'd6, v); chk("R9 fiq mask zero", v, 0);

    irq_src = 32'h0000_FF3C; fiq_src = 32'hA5A5_0001;
    rd(4'd1, v); chk("R1 raw irq no mask", v, 32'h0000_FF3C);
    rd(4'd0, v); chk("R2 masked irq zero mask", v, 0);
    acc(1, 4'd2, 32'h0000_00F0);
    acc(1, 4'd2, 32'h0000_000F);
    rd(4'd2, v); chk("R3 set ors", v, 32'h0000_00FF);
    chk("R7 irq high", {31'b0, irq}, 1);
    acc(1, 4'd3, 32'h0000_003C);
    rd(4'd3, v); chk("R4 clear", v, 32'h0000_00C3);
    rd(4'd0, v); chk("R2 masked irq", v, 32'h0000_FF3C & 32'hC3);
    acc(1, 4'd6, 32'hA5A5_0000);
    rd(4'd2, v); chk("R5 irq mask untouched", v, 32'h0000_00C3);
    rd(4'd6, v); chk("R5 fiq mask own", v, 32'hA5A5_0000);
    rd(4'd5, v); chk("R1 raw fiq", v, 32'hA5A5_0001);
    acc(1, 4'd0, 32'hFFFF_FFFF);
    acc(1, 4'd5, 32'hFFFF_FFFF);
    rd(4'd2, v); chk("R6 irq mask after status write", v, 32'h0000_00C3);
    rd(4'd6, v); chk("R6 fiq mask after status write", v, 32'hA5A5_0000);
    acc(1, 4'd10, 32'hFFFF_FFFF);
    rd(4'd12, v); chk("R10 illegal read zero", v, 0);
    rd(4'd6, v); chk("R10 fiq mask kept", v, 32'hA5A5_0000);
    fiq_src = 32'h0000_0001; idle(2);
    chk("R7 fiq low", {31'b0, fiq}, 0);
    acc(1, 4'd7, 32'hFFFF_FFFF);
    idle(1);
    chk("R7 fiq low after clear", {31'b0, fiq}, 0);
    acc(1, 4'd6, 32'h0000_0001);
    chk("R7 fiq not yet", {31'b0, fiq}, 0);
    idle(1);
    chk("R7 fiq high next edge", {31'b0, fiq}, 1);

    for (int i = 0; i < 400; i++) begin
      irq_src = $urandom; fiq_src = $urandom & $urandom;
      if ($urandom_range(0, 2) != 0)
        acc(1'($urandom_range(0, 1)), 4'($urandom_range(0, 9)), $urandom);
      else idle(1);
    end
    idle(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule